// File: doc/BRIEF.md
# Sound CPU Address Window Decoder

This block sits beside the secondary sound processor and decides, for every read or write strobe, where the access goes. The lowest quarter of the 64 KB space goes to an 8 KB local RAM that shows up twice. The next 8 KB goes to the write port of the FM synthesis chip. The upper half is a 32 KB window onto the main processor's 24-bit bus. A 9-bit bank value selects which 32 KB slice of that bus the window shows. Any other access is refused and reported as an anomaly.

All outputs are registered. An access strobed in one cycle produces exactly one pulse, on exactly one target, on the next cycle. The main-bus request is a one-cycle valid pulse. It carries the full 24-bit address, the direction and one data byte. The RAM storage, the FM chip and the logic that loads the bank value lie outside this block.

Top module: `snd_addr_decode`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every strobe and valid output is 0.
- R2: A read or write with address bits 15..14 equal to 00 gives ram_re or ram_we one cycle later. ram_addr equals address bits 12..0, so 0x2000-0x3FFF mirror 0x0000-0x1FFF. A write also presents its byte on ram_wdata.
- R3: A write with address bits 15..13 equal to 010 while fm_enable is 1 gives an fm_we pulse one cycle later. fm_addr equals address bits 1..0 and fm_wdata equals the written byte.
- R4: A write to 0x4000-0x5FFF while fm_enable is 0 is dropped. No output pulses, and anomaly stays 0.
- R5: An access with address bit 15 set gives mb_valid one cycle later. mb_addr equals (bank << 15) + address bits 14..0.
- R6: A banked write sets mb_write to 1 and puts its byte on mb_wdata. A banked read sets mb_write to 0. mb_valid lasts one cycle for each strobed cycle.
- R7: Three kinds of access give an anomaly pulse one cycle later and nothing else: an access in 0x6000-0x7FFF, a read in 0x4000-0x5FFF, and a cycle with both rd_en and wr_en set.
- R8: In any cycle at most one of the RAM strobe, fm_we, mb_valid and anomaly is 1. A cycle with no strobe gives all of them 0 one cycle later.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Sound processor address |
| wdata | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| bank | input | 9 | Bank value selecting the main-bus slice |
| fm_enable | input | 1 | Enables writes to the FM chip |
| ram_addr | output | 13 | Local RAM index |
| ram_re | output | 1 | Local RAM read strobe |
| ram_we | output | 1 | Local RAM write strobe |
| ram_wdata | output | 8 | Local RAM write byte |
| fm_addr | output | 2 | FM port register select |
| fm_we | output | 1 | FM port write strobe |
| fm_wdata | output | 8 | FM port write byte |
| mb_valid | output | 1 | Main-bus request pulse |
| mb_write | output | 1 | Main-bus direction, 1 for write |
| mb_addr | output | 24 | Main-bus byte address |
| mb_wdata | output | 8 | Main-bus write byte |
| anomaly | output | 1 | Pulse for an access that hits no region |

## Verification
The bench probes the edges of every region: 0x3FFF against 0x4000, 0x5FFF against 0x6000, 0x7FFF against 0x8000, and the mirror at 0x2000. A decoder that uses too few address bits, or compares against the wrong boundary, would send these accesses to a neighbouring target. Banked accesses use bank values 0, all-ones and mixed patterns. These catch a wrong shift or a carry lost between the bank and the low 15 bits. Other cases cover an FM write with sound disabled, an FM-region read, and a read and write strobed together. A design that treats the first as an anomaly, or lets either of the others through to a target, is reported.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;

  // Coarse region selected by the upper address bits
  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_FM   = 2'd1,
    RGN_HOLE = 2'd2,
    RGN_WIN  = 2'd3
  } region_e;

  // What the decoder does with the current cycle
  typedef enum logic [2:0] {
    ACT_IDLE   = 3'd0,
    ACT_RAM_RD = 3'd1,
    ACT_RAM_WR = 3'd2,
    ACT_FM_WR  = 3'd3,
    ACT_WIN_RD = 3'd4,
    ACT_WIN_WR = 3'd5,
    ACT_BAD    = 3'd6,
    ACT_DROP   = 3'd7
  } action_e;

endpackage

// File: rtl/snd_region_decode.sv
module snd_region_decode
  import snd_dec_pkg::*;
(
  input  logic [2:0] addr_top,   // address bits 15..13
  output region_e    region
);

  function automatic region_e classify(input logic [2:0] top);
    if (top[2])              return RGN_WIN;   // 0x8000-0xFFFF
    else if (top[1] == 1'b0) return RGN_RAM;   // 0x0000-0x3FFF
    else if (top[0] == 1'b0) return RGN_FM;    // 0x4000-0x5FFF
    else                     return RGN_HOLE;  // 0x6000-0x7FFF
  endfunction

  assign region = classify(addr_top);

endmodule

// File: rtl/snd_action_sel.sv
module snd_action_sel
  import snd_dec_pkg::*;
(
  input  region_e region,
  input  logic    rd_en,
  input  logic    wr_en,
  input  logic    fm_enable,
  output action_e action
);

  function automatic action_e pick(input region_e r, input logic rd,
                                   input logic wr, input logic fe);
    if (!rd && !wr) return ACT_IDLE;
    if (rd && wr)   return ACT_BAD;
    case (r)
      RGN_RAM:  return wr ? ACT_RAM_WR : ACT_RAM_RD;
      RGN_FM:   return rd ? ACT_BAD : (fe ? ACT_FM_WR : ACT_DROP);
      RGN_WIN:  return wr ? ACT_WIN_WR : ACT_WIN_RD;
      default:  return ACT_BAD;
    endcase
  endfunction

  assign action = pick(region, rd_en, wr_en, fm_enable);

endmodule

// File: rtl/snd_bank_map.sv
module snd_bank_map #(
  parameter int BANK_W = 9,
  parameter int WIN_W  = 15,
  localparam int OUT_W = BANK_W + WIN_W
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [WIN_W-1:0]  offset,
  output logic [OUT_W-1:0]  bus_addr
);

  // Bank selects a WIN_W-sized slice; offset picks the byte inside it
  function automatic logic [OUT_W-1:0] map(input logic [BANK_W-1:0] b,
                                           input logic [WIN_W-1:0]  o);
    logic [OUT_W-1:0] base;
    base = {{WIN_W{1'b0}}, b} << WIN_W;
    return base + {{BANK_W{1'b0}}, o};
  endfunction

  assign bus_addr = map(bank, offset);

endmodule

// File: rtl/snd_addr_decode.sv
module snd_addr_decode
  import snd_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 9,
  parameter int RAM_AW = 13,
  parameter int WIN_W  = 15,
  parameter int FM_AW  = 2,
  localparam int MB_AW = BANK_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] bank,
  input  logic              fm_enable,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_re,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [FM_AW-1:0]  fm_addr,
  output logic              fm_we,
  output logic [DATA_W-1:0] fm_wdata,
  output logic              mb_valid,
  output logic              mb_write,
  output logic [MB_AW-1:0]  mb_addr,
  output logic [DATA_W-1:0] mb_wdata,
  output logic              anomaly
);

  region_e          region;
  action_e          action;
  logic [MB_AW-1:0] win_addr;

  snd_region_decode u_region (
    .addr_top (addr[ADDR_W-1:ADDR_W-3]),
    .region   (region)
  );

  snd_action_sel u_action (
    .region    (region),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .fm_enable (fm_enable),
    .action    (action)
  );

  snd_bank_map #(.BANK_W(BANK_W), .WIN_W(WIN_W)) u_bank (
    .bank     (bank),
    .offset   (addr[WIN_W-1:0]),
    .bus_addr (win_addr)
  );

  // Named events for the assertions
  logic ev_ram, ev_fm, ev_win, ev_bad;
  assign ev_ram = (action == ACT_RAM_RD) || (action == ACT_RAM_WR);
  assign ev_fm  = (action == ACT_FM_WR);
  assign ev_win = (action == ACT_WIN_RD) || (action == ACT_WIN_WR);
  assign ev_bad = (action == ACT_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_addr  <= '0;
      ram_re    <= 1'b0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
      fm_addr   <= '0;
      fm_we     <= 1'b0;
      fm_wdata  <= '0;
      mb_valid  <= 1'b0;
      mb_write  <= 1'b0;
      mb_addr   <= '0;
      mb_wdata  <= '0;
      anomaly   <= 1'b0;
    end else begin
      ram_re   <= (action == ACT_RAM_RD);
      ram_we   <= (action == ACT_RAM_WR);
      fm_we    <= ev_fm;
      mb_valid <= ev_win;
      mb_write <= (action == ACT_WIN_WR);
      anomaly  <= ev_bad;
      if (ev_ram) begin
        ram_addr  <= addr[RAM_AW-1:0];
        ram_wdata <= wdata;
      end
      if (ev_fm) begin
        fm_addr  <= addr[FM_AW-1:0];
        fm_wdata <= wdata;
      end
      if (ev_win) begin
        mb_addr  <= win_addr;
        mb_wdata <= wdata;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> !(ram_re || ram_we || fm_we || mb_valid || anomaly));

  assert_ram_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re || ram_we) |-> ($past(addr[ADDR_W-1:ADDR_W-2]) == 2'b00
                            && ram_addr == $past(addr[RAM_AW-1:0])));

  assert_fm_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fm_we |-> ($past(fm_enable) && $past(wr_en) && !$past(rd_en)));

  assert_fm_drop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(rd_en) && !$past(fm_enable)
     && $past(addr[ADDR_W-1:ADDR_W-3]) == 3'b010)
    |-> !(fm_we || anomaly || mb_valid || ram_we));

  assert_bank_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mb_valid |-> (mb_addr[WIN_W-1:0] == $past(addr[WIN_W-1:0])
                  && mb_addr[MB_AW-1:WIN_W] == $past(bank)));

  assert_win_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mb_valid |-> (mb_write == $past(wr_en)));

  assert_anomaly_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    anomaly |-> ($past(rd_en) || $past(wr_en)));

  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_re || ram_we, fm_we, mb_valid, anomaly}));

  assert_idle_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rd_en) && !$past(wr_en))
    |-> !(ram_re || ram_we || fm_we || mb_valid || anomaly));

endmodule

// File: tb/snd_addr_decode_tb.sv
module snd_addr_decode_tb_top;

  localparam int CLK_PERIOD = 10;

  // kind: 0 idle, 1 ram rd, 2 ram wr, 3 fm wr, 4 win rd, 5 win wr, 6 anomaly
  typedef struct packed {
    logic [15:0] a;
    logic [7:0]  d;
    logic        rd;
    logic        wr;
    logic [8:0]  bk;
    logic        fe;
    logic [2:0]  kind;
    logic [23:0] ea;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{16'h0123, 8'h5A, 1'b0, 1'b1, 9'h000, 1'b0, 3'd2, 24'h000123},
    '{16'h2123, 8'h00, 1'b1, 1'b0, 9'h000, 1'b0, 3'd1, 24'h000123},
    '{16'h3FFF, 8'hE1, 1'b0, 1'b1, 9'h000, 1'b0, 3'd2, 24'h001FFF},
    '{16'h4001, 8'h2B, 1'b0, 1'b1, 9'h000, 1'b1, 3'd3, 24'h000001},
    '{16'h5FFE, 8'h77, 1'b0, 1'b1, 9'h000, 1'b1, 3'd3, 24'h000002},
    '{16'h4000, 8'h99, 1'b0, 1'b1, 9'h000, 1'b0, 3'd0, 24'h000000},
    '{16'h4000, 8'h00, 1'b1, 1'b0, 9'h000, 1'b1, 3'd6, 24'h000000},
    '{16'h6000, 8'h00, 1'b1, 1'b0, 9'h000, 1'b1, 3'd6, 24'h000000},
    '{16'h7FFF, 8'h11, 1'b0, 1'b1, 9'h000, 1'b1, 3'd6, 24'h000000},
    '{16'h8000, 8'h00, 1'b1, 1'b0, 9'h000, 1'b0, 3'd4, 24'h000000},
    '{16'hFFFF, 8'hC3, 1'b0, 1'b1, 9'h1FF, 1'b0, 3'd5, 24'hFFFFFF},
    '{16'h9234, 8'h00, 1'b1, 1'b0, 9'h0A5, 1'b0, 3'd4, 24'h529234},
    '{16'hC000, 8'h3C, 1'b0, 1'b1, 9'h155, 1'b0, 3'd5, 24'hAAC000},
    '{16'h8001, 8'h44, 1'b1, 1'b1, 9'h001, 1'b1, 3'd6, 24'h000000},
    '{16'h0000, 8'h00, 1'b1, 1'b1, 9'h000, 1'b1, 3'd6, 24'h000000},
    '{16'h1234, 8'h00, 1'b0, 1'b0, 9'h0FF, 1'b1, 3'd0, 24'h000000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [8:0]  bank = '0;
  logic        fm_enable = 1'b0;
  logic [12:0] ram_addr;
  logic        ram_re, ram_we;
  logic [7:0]  ram_wdata;
  logic [1:0]  fm_addr;
  logic        fm_we;
  logic [7:0]  fm_wdata;
  logic        mb_valid, mb_write;
  logic [23:0] mb_addr;
  logic [7:0]  mb_wdata;
  logic        anomaly;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_addr_decode dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .wr_en(wr_en), .bank(bank), .fm_enable(fm_enable),
    .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .fm_addr(fm_addr), .fm_we(fm_we),
    .fm_wdata(fm_wdata), .mb_valid(mb_valid), .mb_write(mb_write),
    .mb_addr(mb_addr), .mb_wdata(mb_wdata), .anomaly(anomaly)
  );

  function automatic string req_of(input logic [2:0] k);
    case (k)
      3'd1, 3'd2: return "R2";
      3'd3:       return "R3";
      3'd4:       return "R5";
      3'd5:       return "R6";
      3'd6:       return "R7";
      default:    return "R8/R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // strobe vector {ram_re, ram_we, fm_we, mb_valid, mb_write, anomaly}
  function automatic logic [5:0] strobes_for(input logic [2:0] k);
    case (k)
      3'd1: return 6'b100000;
      3'd2: return 6'b010000;
      3'd3: return 6'b001000;
      3'd4: return 6'b000100;
      3'd5: return 6'b000110;
      3'd6: return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic [5:0] strobes_seen();
    return {ram_re, ram_we, fm_we, mb_valid, mb_write, anomaly};
  endfunction

  task automatic apply(input vec_t v);
    addr = v.a; wdata = v.d; rd_en = v.rd; wr_en = v.wr;
    bank = v.bk; fm_enable = v.fe;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_cycle();
    rd_en = 1'b0; wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with strobes active during reset
    rd_en = 1'b1; wr_en = 1'b0; addr = 16'h8000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(strobes_seen() == 6'b0, "R1", {26'b0, strobes_seen()}, 32'h0);
    rd_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(strobes_seen() == 6'b0, "R1", {26'b0, strobes_seen()}, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      logic [5:0] es;
      v = VEC[i];
      apply(v);
      es = strobes_for(v.kind);
      check(strobes_seen() == es, req_of(v.kind),
            {26'b0, strobes_seen()}, {26'b0, es});
      case (v.kind)
        3'd1: check(ram_addr == v.ea[12:0], "R2", {19'b0, ram_addr}, v.ea);
        3'd2: check(ram_addr == v.ea[12:0] && ram_wdata == v.d, "R2",
                    {11'b0, ram_wdata, ram_addr}, {11'b0, v.d, v.ea[12:0]});
        3'd3: check(fm_addr == v.ea[1:0] && fm_wdata == v.d, "R3",
                    {22'b0, fm_wdata, fm_addr}, {22'b0, v.d, v.ea[1:0]});
        3'd4: check(mb_addr == v.ea, "R5", {8'b0, mb_addr}, v.ea);
        3'd5: check(mb_addr == v.ea && mb_wdata == v.d, "R6",
                    {mb_wdata, mb_addr}, {v.d, v.ea});
        default: ;
      endcase
    end

    // R6: window request lasts a single cycle
    apply('{16'hA000, 8'h81, 1'b0, 1'b1, 9'h003, 1'b0, 3'd5, 24'h01A000});
    check(mb_valid && mb_addr == 24'h01A000 && mb_wdata == 8'h81, "R6",
          {mb_wdata, mb_addr}, {8'h81, 24'h01A000});
    idle_cycle();
    check(!mb_valid, "R6", {31'b0, mb_valid}, 32'h0);

    // R2: back-to-back RAM writes each produce their own pulse
    apply('{16'h0010, 8'hA1, 1'b0, 1'b1, 9'h000, 1'b0, 3'd2, 24'h000010});
    check(ram_we && ram_addr == 13'h0010 && ram_wdata == 8'hA1, "R2",
          {11'b0, ram_wdata, ram_addr}, {11'b0, 8'hA1, 13'h0010});
    apply('{16'h2011, 8'hB2, 1'b0, 1'b1, 9'h000, 1'b0, 3'd2, 24'h000011});
    check(ram_we && ram_addr == 13'h0011 && ram_wdata == 8'hB2, "R2",
          {11'b0, ram_wdata, ram_addr}, {11'b0, 8'hB2, 13'h0011});

    // R4: dropped FM write leaves FM port data unchanged
    apply('{16'h4002, 8'h55, 1'b0, 1'b1, 9'h000, 1'b1, 3'd3, 24'h000002});
    apply('{16'h4001, 8'hEE, 1'b0, 1'b1, 9'h000, 1'b0, 3'd0, 24'h000000});
    check(!fm_we && !anomaly && fm_wdata == 8'h55 && fm_addr == 2'd2, "R4",
          {22'b0, fm_wdata, fm_addr}, {22'b0, 8'h55, 2'd2});

    // R8: no strobe gives idle outputs
    idle_cycle();
    check(strobes_seen() == 6'b0, "R8", {26'b0, strobes_seen()}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule